// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Pointer

This block holds the address pointer a host uses to reach an internal memory indirectly. The host first writes a start address into the pointer. It then reads or writes a data window, and each such access is sent to the memory at the current pointer value. A control bit enables auto-increment. When it is set, every data-window access moves the pointer on by one, so a host can stream through consecutive memory words without rewriting the address.

The host strobes come from a host clock that runs at one quarter of the fabric clock rate. The strobes are registered in the fabric clock. A free-running two-bit phase counter marks one fabric cycle in four as the update slot. Every register change is made through a clock enable in that slot, so no clock is gated from the strobes. A host access can stay active for several slots, but an edge tracker lets it act only once. The memory array and the host address decoder sit outside this block.

Top module: `aip_indirect_ptr`

## Requirements
- R1: After reset the pointer is 0, the auto-increment bit is 0, and neither memory strobe is asserted.
- R2: A write access (host_wr_n low, host_rd_n high, host_cs high) with host_ptr_sel high loads the pointer from the low log2(MEM_DEPTH) bits of host_wdata. Upper data bits are dropped.
- R3: A write access with host_ctl_sel high sets the auto-increment bit to host_wdata bit 0. This register holds its value until the next such write.
- R4: A data-window access (host_cs and host_data_sel high) with host_rd_n low gives exactly one mem_rd pulse, and mem_addr equals the pointer during that pulse. A write access gives one mem_wr pulse, with mem_wdata equal to the host data.
- R5: When the auto-increment bit is 1, the pointer advances by one after each data-window access. When the bit is 0, data accesses leave the pointer unchanged.
- R6: An increment from the top address MEM_DEPTH-1 wraps the pointer to 0.
- R7: An access acts only once, however many fabric cycles its strobes are held. A new action needs the strobes to be seen inactive in an update slot first.
- R8: Actions occur only in update slots, which repeat every four fabric clocks. Any two memory pulses are therefore a multiple of four cycles apart.
- R9: If host_ptr_sel and host_data_sel are both active in a write access, the pointer takes the loaded value and the increment is dropped.
- R10: Strobes are ignored when host_cs is low, or when host_rd_n and host_wr_n are both high. No memory pulse occurs and the pointer does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, four times the host rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Device select, active high |
| host_ptr_sel | input | 1 | Pointer register select |
| host_data_sel | input | 1 | Data window select |
| host_ctl_sel | input | 1 | Control register select |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DW | Host write data |
| mem_addr | output | log2(MEM_DEPTH) | Current pointer, used as the memory address |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | DW | Data for memory writes |
| auto_inc | output | 1 | Current auto-increment bit |

## Verification
Some properties are checked by assertions on every cycle:
- the phase counter steps by one each cycle;
- memory pulses occur only in update slots;
- one access never produces two back-to-back actions;
- the pointer stays in range and holds when it has no command;
- the pointer wraps to zero from the top address;
- a load beats an increment.

Other behaviour can only be shown by the bench's scenarios. These include the values that reach the pointer and control register through real host transactions, and the full sweep of start addresses with reads and writes. They also cover held strobes, conflicting selects and ignored strobes, all observed at the memory-side pins.

// File: rtl/aip_pkg.sv
package aip_pkg;
  // Decoded host request, strobes converted to active high.
  typedef struct packed {
    logic cs;
    logic ptr_sel;
    logic data_sel;
    logic ctl_sel;
    logic rd;
    logic wr;
  } aip_req_t;

  localparam int unsigned AIP_PHASE_W = 2;
endpackage

// File: rtl/aip_phase_gen.sv
module aip_phase_gen #(
  parameter int unsigned PH_W    = 2,
  parameter int unsigned TICK_AT = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick_o = (phase_q == PH_W'(TICK_AT));

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_q == PH_W'($past(phase_q) + PH_W'(1))) else $error("phase skip"); // R8
endmodule

// File: rtl/aip_strobe_decode.sv
module aip_strobe_decode
  import aip_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cs_i,
  input  logic          ptr_sel_i,
  input  logic          data_sel_i,
  input  logic          ctl_sel_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] wdata_i,
  output logic          load_ptr_o,
  output logic          load_ctl_o,
  output logic          data_rd_o,
  output logic          data_wr_o,
  output logic [DW-1:0] wdata_o
);
  aip_req_t        req_d, req_q;
  logic [DW-1:0]   wdata_q;
  logic            busy_q, busy_d;
  logic            active, fresh;

  always_comb begin
    req_d.cs       = cs_i;
    req_d.ptr_sel  = ptr_sel_i;
    req_d.data_sel = data_sel_i;
    req_d.ctl_sel  = ctl_sel_i;
    req_d.rd       = ~rd_n_i;
    req_d.wr       = ~wr_n_i & rd_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      wdata_q <= '0;
    end else begin
      req_q   <= req_d;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    active = req_q.cs & (req_q.rd | req_q.wr);
    fresh  = tick_i & active & ~busy_q;
    busy_d = tick_i ? active : busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign load_ptr_o = fresh & req_q.ptr_sel & req_q.wr;
  assign load_ctl_o = fresh & req_q.ctl_sel & req_q.wr;
  assign data_rd_o  = fresh & req_q.data_sel & req_q.rd;
  assign data_wr_o  = fresh & req_q.data_sel & req_q.wr;
  assign wdata_o    = wdata_q;

  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_o || data_wr_o || load_ptr_o || load_ctl_o) |-> tick_i) else $error("off-slot action"); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_o || data_wr_o) |=> !(data_rd_o || data_wr_o)) else $error("double action"); // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_rd_o, data_wr_o})) else $error("rd and wr together"); // R4
endmodule

// File: rtl/aip_ptr_reg.sv
module aip_ptr_reg #(
  parameter int unsigned DW        = 8,
  parameter int unsigned MEM_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_ptr_i,
  input  logic                         load_ctl_i,
  input  logic                         data_acc_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [$clog2(MEM_DEPTH)-1:0] ptr_o,
  output logic                         auto_o
);
  localparam int unsigned AW = $clog2(MEM_DEPTH);
  localparam logic [AW-1:0] TOP = AW'(MEM_DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d, ld_val, inc_val;
  logic          auto_q, auto_d;
  logic          ptr_en, auto_en;

  always_comb begin
    ld_val  = (wdata_i[AW-1:0] > TOP) ? '0 : wdata_i[AW-1:0];
    inc_val = (ptr_q == TOP) ? '0 : ptr_q + AW'(1);
    ptr_en  = load_ptr_i | (data_acc_i & auto_q);
    ptr_d   = load_ptr_i ? ld_val : inc_val;
    auto_en = load_ctl_i;
    auto_d  = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (auto_en) auto_q <= auto_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign auto_o = auto_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= TOP) else $error("pointer out of range"); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ptr_i && !(data_acc_i && auto_q)) |=> $stable(ptr_q)) else $error("pointer drift"); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc_i && auto_q && !load_ptr_i && ptr_q == TOP) |=> ptr_q == '0) else $error("no wrap"); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ptr_i && data_acc_i) |=> ptr_q == $past(ld_val)) else $error("increment beat load"); // R9
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ctl_i |=> $stable(auto_q)) else $error("control bit drift"); // R3
endmodule

// File: rtl/aip_indirect_ptr.sv
module aip_indirect_ptr
  import aip_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned MEM_DEPTH = 16,
  parameter int unsigned TICK_AT   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_cs,
  input  logic                         host_ptr_sel,
  input  logic                         host_data_sel,
  input  logic                         host_ctl_sel,
  input  logic                         host_rd_n,
  input  logic                         host_wr_n,
  input  logic [DW-1:0]                host_wdata,
  output logic [$clog2(MEM_DEPTH)-1:0] mem_addr,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic [DW-1:0]                mem_wdata,
  output logic                         auto_inc
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       tick;
  logic       load_ptr, load_ctl, data_rd, data_wr;
  logic [DW-1:0] wdata_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  aip_phase_gen #(
    .PH_W    (AIP_PHASE_W),
    .TICK_AT (TICK_AT)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_o (tick)
  );

  aip_strobe_decode #(.DW(DW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_i     (tick),
    .cs_i       (host_cs),
    .ptr_sel_i  (host_ptr_sel),
    .data_sel_i (host_data_sel),
    .ctl_sel_i  (host_ctl_sel),
    .rd_n_i     (host_rd_n),
    .wr_n_i     (host_wr_n),
    .wdata_i    (host_wdata),
    .load_ptr_o (load_ptr),
    .load_ctl_o (load_ctl),
    .data_rd_o  (data_rd),
    .data_wr_o  (data_wr),
    .wdata_o    (wdata_cap)
  );

  aip_ptr_reg #(.DW(DW), .MEM_DEPTH(MEM_DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_ptr_i (load_ptr),
    .load_ctl_i (load_ctl),
    .data_acc_i (data_rd | data_wr),
    .wdata_i    (wdata_cap),
    .ptr_o      (mem_addr),
    .auto_o     (auto_inc)
  );

  assign mem_rd    = data_rd;
  assign mem_wr    = data_wr;
  assign mem_wdata = wdata_cap;
endmodule

// File: tb/sim_aip_indirect_ptr.sv
module sim_aip_indirect_ptr;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic cs, psel, dsel, csel, rd_n, wr_n;
  logic [DW-1:0] wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, auto_inc;
  logic [DW-1:0] mem_wdata;

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0, wr_cnt = 0, cyc = 0, last_pulse = -1, spacing_bad = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_wdata;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aip_indirect_ptr #(.DW(DW), .MEM_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .host_cs(cs), .host_ptr_sel(psel),
    .host_data_sel(dsel), .host_ctl_sel(csel), .host_rd_n(rd_n),
    .host_wr_n(wr_n), .host_wdata(wdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .auto_inc(auto_inc)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && (mem_rd || mem_wr)) begin
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      if (mem_wr) wr_cnt <= wr_cnt + 1;
      last_addr  <= mem_addr;
      last_wdata <= mem_wdata;
      if (last_pulse >= 0 && ((cyc - last_pulse) % 4) != 0) spacing_bad <= spacing_bad + 1;
      last_pulse <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cs = 0; psel = 0; dsel = 0; csel = 0; rd_n = 1; wr_n = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic hop(input bit c, input bit p, input bit d, input bit k,
                     input bit r_n, input bit w_n, input logic [DW-1:0] v, input int hold);
    @(negedge clk);
    cs = c; psel = p; dsel = d; csel = k; rd_n = r_n; wr_n = w_n; wdata = v;
    repeat (hold) @(negedge clk);
    idle(8);
  endtask

  initial begin
    cs = 0; psel = 0; dsel = 0; csel = 0; rd_n = 1; wr_n = 1; wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(mem_addr == 0, "R1 pointer", mem_addr, 0);
    chk(auto_inc == 0, "R1 auto", auto_inc, 0);
    chk(rd_cnt + wr_cnt == 0, "R1 strobes", rd_cnt + wr_cnt, 0);

    // R2 load, upper bits dropped
    hop(1, 1, 0, 0, 1, 0, 8'h05, 8);
    chk(mem_addr == 5, "R2 load", mem_addr, 5);
    hop(1, 1, 0, 0, 1, 0, 8'hF3, 8);
    chk(mem_addr == 3, "R2 upper bits", mem_addr, 3);

    // R4/R5 read and write with auto off
    hop(1, 0, 1, 0, 0, 1, 8'h00, 8);
    chk(rd_cnt == 1, "R4 read pulse", rd_cnt, 1);
    chk(last_addr == 3, "R4 read addr", last_addr, 3);
    chk(mem_addr == 3, "R5 no inc when off", mem_addr, 3);
    hop(1, 0, 1, 0, 1, 0, 8'hA5, 8);
    chk(wr_cnt == 1, "R4 write pulse", wr_cnt, 1);
    chk(last_wdata == 8'hA5, "R4 write data", last_wdata, 8'hA5);

    // R3 set auto
    hop(1, 0, 0, 1, 1, 0, 8'h01, 8);
    chk(auto_inc == 1, "R3 set", auto_inc, 1);

    // R5/R6 sweep of start addresses
    for (int s = 0; s < DEPTH; s++) begin
      int r0;
      hop(1, 1, 0, 0, 1, 0, DW'(s), 8);
      r0 = rd_cnt;
      hop(1, 0, 1, 0, 0, 1, 8'h00, 8);
      chk(rd_cnt == r0 + 1 && last_addr == AW'(s), "R4 sweep read", last_addr, s);
      chk(mem_addr == AW'((s + 1) % DEPTH), "R5 R6 inc after read", mem_addr, (s + 1) % DEPTH);
      hop(1, 0, 1, 0, 1, 0, DW'(s * 7), 8);
      chk(last_wdata == DW'(s * 7) && last_addr == AW'((s + 1) % DEPTH), "R4 sweep write", last_wdata, s * 7);
      chk(mem_addr == AW'((s + 2) % DEPTH), "R5 R6 inc after write", mem_addr, (s + 2) % DEPTH);
    end

    // R7 long strobe
    begin
      int r0;
      hop(1, 1, 0, 0, 1, 0, 8'h0A, 8);
      r0 = rd_cnt;
      hop(1, 0, 1, 0, 0, 1, 8'h00, 40);
      chk(rd_cnt == r0 + 1, "R7 one pulse", rd_cnt - r0, 1);
      chk(mem_addr == 11, "R7 one increment", mem_addr, 11);
    end

    // R9 load beats increment
    hop(1, 1, 1, 0, 1, 0, 8'h09, 8);
    chk(mem_addr == 9, "R9 load wins", mem_addr, 9);

    // R10 ignored strobes
    begin
      int p0;
      p0 = rd_cnt + wr_cnt;
      hop(0, 0, 1, 0, 0, 1, 8'h00, 8);
      hop(0, 1, 0, 0, 1, 0, 8'h02, 8);
      hop(1, 0, 1, 0, 1, 1, 8'h00, 8);
      chk(rd_cnt + wr_cnt == p0, "R10 no pulse", rd_cnt + wr_cnt - p0, 0);
      chk(mem_addr == 9, "R10 pointer kept", mem_addr, 9);
    end

    // R3 clear auto
    hop(1, 0, 0, 1, 1, 0, 8'hFE, 8);
    chk(auto_inc == 0, "R3 clear", auto_inc, 0);
    hop(1, 0, 1, 0, 0, 1, 8'h00, 8);
    chk(mem_addr == 9, "R5 off after clear", mem_addr, 9);

    // R8 slot spacing
    chk(spacing_bad == 0, "R8 spacing", spacing_bad, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule